// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Cycle Controller

This block runs read and write cycles on a shared bus whose low address bits and data travel on the same lines. A requester hands it an address, a memory-or-port flag, a read-or-write flag and write data. The block then steps through a fixed sequence of clock states:

- It puts the low address on the shared lines and pulses an address latch enable. The latch output holds the full address for the rest of the cycle.
- It turns the shared lines over to data.
- It drives the active-low read or write strobe.
- It steers a bidirectional data transceiver through a direction line and an active-low enable.

A ready input passes through a two-flop synchroniser and stretches the cycle with wait states. A hold input lets another master take the bus. When the hold is granted, every output enable of the block is withdrawn.

A cycle is T1, T2, T3, zero or more wait states, then T4. A request seen while idle or in T4 starts T1 on the next clock, so cycles can run back to back. The requester keeps `req_i` and the request fields steady until `req_ack_o` is high. The requester treats `done_o` as the end of the cycle. For a read, `rd_data_o` is valid while `done_o` is high.

Top module: `bus_cycle_ctrl`

## Requirements
- R1: While rst_ni is low, rd_no, wr_no and den_no are 1, and ale_o, ad_oe_o and hlda_o are 0.
- R2: In T1, ale_o is 1 for exactly one clock, ad_oe_o is 1, ad_o carries address bits [DATA_W-1:0], and both strobes are high. From T2 through T4, addr_latched_o equals the full requested address.
- R3: mio_o is 1 for a memory cycle and 0 for a port cycle. It is set in T1 and holds through T4.
- R4: For a read, rd_no is 0 in T2, T3 and every wait state. For a write, wr_no is 0 in the same states. Both strobes are 1 in T1 and T4, and they are never 0 together.
- R5: dtr_o is 1 for a write and 0 for a read. It changes only in the clock where ale_o is 1.
- R6: den_no is 0 from T2 through the last wait state for a write, and from T2 through T4 for a read. It is 1 in T1 and while idle.
- R7: For a write, ad_oe_o is 1 and ad_o equals the write data from T2 through T4. For a read, ad_oe_o is 0 from T2 through T4. In that case rd_data_o holds the value on ad_i at the final T3 or wait state, and is shown while done_o is 1 in T4.
- R8: ready_i passes through two flops. If ready_i rises in the k-th clock after the T1 clock (k = 0 meaning the T1 clock itself), the cycle has exactly k wait states. If ready_i stays high, there are no wait states.
- R9: hold_i is sampled only while idle or in T4, and hlda_o rises one clock later. A hold raised during T1 to the last wait state does not change that cycle. While hlda_o is 1, ad_oe_o and ctrl_oe_o are 0, den_no is 1 and ale_o is 0.
- R10: hlda_o falls one clock after hold_i is seen low. A pending request starts T1 on the clock after that.
- R11: A request present in T4 with hold_i low starts T1 on the next clock, with no idle clock between. A hold seen together with a request wins over the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pending |
| req_addr_i | input | ADDR_W | Request address |
| req_mem_i | input | 1 | 1 = memory, 0 = port |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | DATA_W | Write data |
| req_ack_o | output | 1 | High in T1: request taken |
| done_o | output | 1 | High in T4 |
| rd_data_o | output | DATA_W | Read data captured from the bus |
| ad_o | output | DATA_W | Shared address/data lines, outbound value |
| ad_oe_o | output | 1 | Output enable for ad_o |
| ad_i | input | DATA_W | Shared address/data lines, inbound value |
| addr_latched_o | output | ADDR_W | Address latch output |
| ale_o | output | 1 | Address latch enable |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| mio_o | output | 1 | Memory (1) or port (0) select |
| ctrl_oe_o | output | 1 | Output enable for strobes and select |
| den_no | output | 1 | Transceiver enable, active low |
| dtr_o | output | 1 | Transceiver direction, 1 = outward |
| ready_i | input | 1 | Asynchronous ready |
| hold_i | input | 1 | Bus hold request |
| hlda_o | output | 1 | Bus hold granted |

## Verification
The bench builds the block with ADDR_W = 12 and DATA_W = 8. This keeps the latched high byte narrow while the address and data patterns still differ in every bit. It sweeps every pairing of memory/port and read/write, against wait counts from zero to three and two addresses each. In every clock of each cycle it checks strobes, latch, enable and direction against values it works out from the state count. Separate runs cover hold raised while idle, hold raised mid-cycle alongside a pending request, and back-to-back cycles with no idle clock between them.

// File: rtl/bus_cycle_pkg.sv
package bus_cycle_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_T3   = 3'd3,
    ST_TW   = 3'd4,
    ST_T4   = 3'd5,
    ST_HOLD = 3'd6
  } bus_state_e;
endpackage

// File: rtl/bcc_ready_sync.sv
module bcc_ready_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic sync_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q[g] <= 1'b0;
      else         chain_q[g] <= (g == 0) ? async_i : chain_q[(g == 0) ? 0 : g-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/bcc_addr_latch.sv
module bcc_addr_latch #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              le_i,
  input  logic [DATA_W-1:0] lo_i,
  input  logic [HI_W-1:0]   hi_i,
  output logic [ADDR_W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (le_i) q_o <= {hi_i, lo_i};
  end
endmodule

// File: rtl/bcc_seq.sv
module bcc_seq
  import bus_cycle_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_mem_i,
  input  logic              req_wr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic              ready_s_i,
  input  logic              hold_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              req_ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              mio_o,
  output logic              ctrl_oe_o,
  output logic              den_no,
  output logic              dtr_o,
  output logic              hlda_o
);
  bus_state_e state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic mem_q, wr_q;
  logic strobe, data_ph;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: state_d = hold_i ? ST_HOLD : (req_i ? ST_T1 : ST_IDLE);
      ST_T1:   state_d = ST_T2;
      ST_T2:   state_d = ST_T3;
      ST_T3,
      ST_TW:   state_d = ready_s_i ? ST_T4 : ST_TW;
      ST_T4:   state_d = hold_i ? ST_HOLD : (req_i ? ST_T1 : ST_IDLE);
      ST_HOLD: state_d = hold_i ? ST_HOLD : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mem_q   <= 1'b0;
      wr_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_d == ST_T1) begin
        addr_q  <= req_addr_i;
        wdata_q <= req_wdata_i;
        mem_q   <= req_mem_i;
        wr_q    <= req_wr_i;
      end
      // capture read data on the clock that ends the strobe
      if ((state_q == ST_T3 || state_q == ST_TW) && ready_s_i && !wr_q)
        rdata_q <= ad_i;
    end
  end

  assign strobe    = (state_q == ST_T2) || (state_q == ST_T3) || (state_q == ST_TW);
  assign data_ph   = strobe || (state_q == ST_T4);
  assign ale_o     = (state_q == ST_T1);
  assign ad_oe_o   = ale_o || (wr_q && data_ph);
  assign ad_o      = ale_o ? addr_q[DATA_W-1:0] : wdata_q;
  assign rd_no     = !(strobe && !wr_q);
  assign wr_no     = !(strobe && wr_q);
  assign den_no    = !(strobe || (state_q == ST_T4 && !wr_q));
  assign mio_o     = mem_q;
  assign dtr_o     = wr_q;
  assign hlda_o    = (state_q == ST_HOLD);
  assign ctrl_oe_o = !hlda_o;
  assign req_ack_o = ale_o;
  assign done_o    = (state_q == ST_T4);
  assign rd_data_o = rdata_q;
  assign addr_o    = addr_q;
endmodule

// File: rtl/bus_cycle_ctrl.sv
module bus_cycle_ctrl #(
  parameter int ADDR_W      = 20,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_mem_i,
  input  logic              req_wr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              req_ack_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe_o,
  input  logic [DATA_W-1:0] ad_i,
  output logic [ADDR_W-1:0] addr_latched_o,
  output logic              ale_o,
  output logic              rd_no,
  output logic              wr_no,
  output logic              mio_o,
  output logic              ctrl_oe_o,
  output logic              den_no,
  output logic              dtr_o,
  input  logic              ready_i,
  input  logic              hold_i,
  output logic              hlda_o
);
  logic              ready_s;
  logic [ADDR_W-1:0] cur_addr;

  bcc_ready_sync #(.STAGES(SYNC_STAGES)) u_rdy (
    .clk_i(clk_i), .rst_ni(rst_ni), .async_i(ready_i), .sync_o(ready_s)
  );

  bcc_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .req_addr_i(req_addr_i), .req_mem_i(req_mem_i),
    .req_wr_i(req_wr_i), .req_wdata_i(req_wdata_i),
    .ready_s_i(ready_s), .hold_i(hold_i), .ad_i(ad_i),
    .addr_o(cur_addr), .req_ack_o(req_ack_o), .done_o(done_o),
    .rd_data_o(rd_data_o), .ad_o(ad_o), .ad_oe_o(ad_oe_o), .ale_o(ale_o),
    .rd_no(rd_no), .wr_no(wr_no), .mio_o(mio_o), .ctrl_oe_o(ctrl_oe_o),
    .den_no(den_no), .dtr_o(dtr_o), .hlda_o(hlda_o)
  );

  // latch fed from the shared lines, as an external latch would be
  bcc_addr_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lat (
    .clk_i(clk_i), .rst_ni(rst_ni), .le_i(ale_o), .lo_i(ad_o),
    .hi_i(cur_addr[ADDR_W-1:DATA_W]), .q_o(addr_latched_o)
  );

  initial begin
    if (HI_W < 1) $error("ADDR_W must exceed DATA_W");
  end
endmodule

// File: rtl/bcc_checker.sv
module bcc_checker #(
  parameter int ADDR_W = 20,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              hold_i,
  input logic [DATA_W-1:0] ad_o,
  input logic              ad_oe_o,
  input logic [ADDR_W-1:0] addr_latched_o,
  input logic              ale_o,
  input logic              rd_no,
  input logic              wr_no,
  input logic              mio_o,
  input logic              ctrl_oe_o,
  input logic              den_no,
  input logic              dtr_o,
  input logic              hlda_o
);
  AST_ALE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> !ale_o); // R2
  AST_ALE_ADDR_PHASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (ad_oe_o && rd_no && wr_no)); // R2
  AST_LATCH_TAKES_LO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (addr_latched_o[DATA_W-1:0] == $past(ad_o))); // R2
  AST_MIO_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_o |-> $stable(mio_o)); // R3
  AST_STROBE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_no || wr_no)); // R4
  AST_DTR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ale_o |-> $stable(dtr_o)); // R5
  AST_HOLD_FLOATS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hlda_o |-> (!ad_oe_o && !ctrl_oe_o && den_no && !ale_o)); // R9
  AST_HOLD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hlda_o && !hold_i) |=> !hlda_o); // R10
endmodule

bind bus_cycle_ctrl bcc_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .hold_i(hold_i), .ad_o(ad_o),
  .ad_oe_o(ad_oe_o), .addr_latched_o(addr_latched_o), .ale_o(ale_o),
  .rd_no(rd_no), .wr_no(wr_no), .mio_o(mio_o), .ctrl_oe_o(ctrl_oe_o),
  .den_no(den_no), .dtr_o(dtr_o), .hlda_o(hlda_o)
);

// File: tb/sim_bus_cycle_ctrl.sv
`timescale 1ns/1ps
module sim_bus_cycle_ctrl;
  localparam int AW = 12;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req, req_mem, req_wr, ready, hold;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, ad_in;
  logic          req_ack, done, ad_oe, ale, rd_n, wr_n, mio, ctrl_oe, den_n, dtr, hlda;
  logic [DW-1:0] rd_data, ad_out;
  logic [AW-1:0] addr_lat;

  int checks = 0;
  int errors = 0;

  bus_cycle_ctrl #(.ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_addr_i(req_addr),
    .req_mem_i(req_mem), .req_wr_i(req_wr), .req_wdata_i(req_wdata),
    .req_ack_o(req_ack), .done_o(done), .rd_data_o(rd_data), .ad_o(ad_out),
    .ad_oe_o(ad_oe), .ad_i(ad_in), .addr_latched_o(addr_lat), .ale_o(ale),
    .rd_no(rd_n), .wr_no(wr_n), .mio_o(mio), .ctrl_oe_o(ctrl_oe), .den_no(den_n),
    .dtr_o(dtr), .ready_i(ready), .hold_i(hold), .hlda_o(hlda)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  // one full cycle; k = clocks after T1 at which ready_i rises
  task automatic run_cycle(input logic m, input logic w, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int k);
    int idx;
    int nstb;
    logic [DW-1:0] din;
    din = a[DW-1:0] ^ 8'h5A;
    @(negedge clk);
    req = 1'b1; req_mem = m; req_wr = w; req_addr = a; req_wdata = wd;
    ready = 1'b0; ad_in = din;
    @(negedge clk);
    chk(req_ack && ale, "R2", "ale in T1", {ale, req_ack}, 2'b11);
    chk(ad_oe && ad_out == a[DW-1:0], "R2", "address on lines", ad_out, a[DW-1:0]);
    chk(rd_n && wr_n && den_n, "R4", "strobes idle in T1", {rd_n, wr_n, den_n}, 3'b111);
    chk(mio == m, "R3", "mio in T1", mio, m);
    chk(dtr == w, "R5", "dtr in T1", dtr, w);
    req = 1'b0;
    if (k == 0) ready = 1'b1;
    idx = 0; nstb = 0;
    forever begin
      @(negedge clk);
      idx++;
      if (done || idx > 20) break;
      nstb++;
      chk(rd_n == w && wr_n == !w, "R4", "strobe level", {rd_n, wr_n}, {w, !w});
      chk(!den_n, "R6", "den active in strobe", den_n, 0);
      chk(addr_lat == a, "R2", "latched address", addr_lat, a);
      chk(mio == m && dtr == w, "R5", "mio/dtr held", {mio, dtr}, {m, w});
      if (w) chk(ad_oe && ad_out == wd, "R7", "write data", ad_out, wd);
      else   chk(!ad_oe, "R7", "lines released on read", ad_oe, 0);
      if (idx == k) ready = 1'b1;
    end
    chk(nstb == 2 + k, "R8", "strobe clocks vs wait count", nstb, 2 + k);
    chk(done && rd_n && wr_n, "R4", "T4 strobes high", {done, rd_n, wr_n}, 3'b111);
    chk(den_n == w, "R6", "den in T4", den_n, w);
    chk(addr_lat == a && mio == m && dtr == w, "R3", "T4 address/mio/dtr",
        {addr_lat, mio, dtr}, {a, m, w});
    if (w) chk(ad_oe && ad_out == wd, "R7", "write data in T4", ad_out, wd);
    else   chk(!ad_oe && rd_data == din, "R7", "read data", rd_data, din);
    ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!ale && den_n && rd_n && wr_n, "R6", "idle outputs", {ale, den_n, rd_n, wr_n}, 4'b0111);
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!done && n < 30) begin @(negedge clk); n++; end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req = 0; req_mem = 0; req_wr = 0; req_addr = '0; req_wdata = '0;
    ready = 0; hold = 0; ad_in = '0;
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && den_n && !ale && !ad_oe && !hlda, "R1", "reset outputs",
        {rd_n, wr_n, den_n, ale, ad_oe, hlda}, 6'b111000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int m = 0; m < 2; m++)
      for (int w = 0; w < 2; w++)
        for (int k = 0; k < 4; k++)
          for (int s = 0; s < 2; s++)
            run_cycle(m[0], w[0], AW'((s ? 12'hA5C : 12'h3C6) ^ (k * 12'h111)),
                      DW'(8'h96 ^ (k << 2) ^ s), k);

    // R9/R10: hold while idle with a request pending
    @(negedge clk);
    hold = 1; req = 1; req_mem = 1; req_wr = 0; req_addr = 12'h7E1; ad_in = 8'h33;
    @(negedge clk);
    chk(hlda, "R9", "hlda one clock after hold", hlda, 1);
    chk(!ad_oe && !ctrl_oe && den_n && !ale, "R9", "floated in hold",
        {ad_oe, ctrl_oe, den_n, ale}, 4'b0010);
    repeat (3) @(negedge clk);
    chk(hlda && !ale, "R9", "request blocked in hold", {hlda, ale}, 2'b10);
    hold = 0;
    @(negedge clk);
    chk(!hlda && !ale, "R10", "hlda drop", {hlda, ale}, 2'b00);
    @(negedge clk);
    chk(ale && ad_out == 8'hE1, "R10", "T1 after release", {ale, ad_out}, {1'b1, 8'hE1});
    req = 0; ready = 1;
    wait_done();
    chk(done, "R10", "cycle after release ends", done, 1);

    // R9/R11: hold raised mid-cycle with request still pending
    repeat (3) @(negedge clk);
    req = 1; req_wr = 1; req_addr = 12'h4D2; req_wdata = 8'hC3;
    @(negedge clk);
    chk(ale, "R9", "T1 of held cycle", ale, 1);
    hold = 1;
    @(negedge clk);
    chk(!hlda && !wr_n, "R9", "T2 undisturbed", {hlda, wr_n}, 2'b00);
    @(negedge clk);
    chk(!hlda && !wr_n, "R9", "T3 undisturbed", {hlda, wr_n}, 2'b00);
    @(negedge clk);
    chk(done && !hlda, "R9", "T4 undisturbed", {done, hlda}, 2'b10);
    @(negedge clk);
    chk(hlda && !ale, "R11", "hold wins over request", {hlda, ale}, 2'b10);
    hold = 0;
    @(negedge clk);
    chk(!hlda, "R10", "hlda falls", hlda, 0);
    @(negedge clk);
    chk(ale, "R10", "pending request starts", ale, 1);
    req = 0;
    wait_done();
    repeat (3) @(negedge clk);

    // R11: back-to-back cycles
    req = 1; req_wr = 0; req_mem = 0; req_addr = 12'h111;
    @(negedge clk);
    chk(ale, "R11", "first T1", ale, 1);
    req_addr = 12'h2F0; req_mem = 1;
    wait_done();
    @(negedge clk);
    chk(ale && ad_out == 8'hF0 && mio, "R11", "next T1 with no idle",
        {ale, mio, ad_out}, {2'b11, 8'hF0});
    req = 0;
    wait_done();
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule